// File: doc/BRIEF.md
# Sign-Driven Successive-Approximation Offset Trim Controller

This controller finds the digital word that cancels an amplifier's input offset. It drives a binary-weighted current DAC. The DAC's current is summed against a fixed opposing current equal to half of full scale, so the net correction can have either sign. During calibration the amplifier runs open loop, and its output sits at one supply rail or the other. The only feedback to the controller is therefore a single sign bit: it is high while the DAC current is still too small (under-compensated) and low once the DAC current has overshot.

A search is launched by a start pulse. It then resolves one bit per decision step, starting at the most significant bit. A decision step lasts a fixed number of clock cycles, which gives the analog loop time to settle. When the last bit is decided, the block raises a one-cycle done pulse and holds the word on its output for normal operation. A scheduler repeats the search on its own after a fixed idle gap so that drift is tracked. A start pulse while the block is idle begins a search at once; a start pulse during a search is ignored.

Top module: `sar_offset_trim`

## Requirements
- R1: After synchronous reset, code_o is 0, busy_o is 0 and done_o is 0. With start_i held low, no search begins for any length of time.
- R2: A start_i pulse sampled while busy_o is 0 raises busy_o on the next cycle. On that cycle code_o is the MSB-only trial word (0x80 for 8 bits): bit CODE_W-1 set and every other bit clear.
- R3: During a search, one bit is decided every STEP_DIV cycles, from the MSB down to the LSB. At each decision edge, sign_i=1 keeps the current trial bit and sign_i=0 clears it; the next lower bit is then set to 1 as the new trial. Between decision edges, code_o does not change.
- R4: The final word is the successive-approximation result. With a monotonic DAC model in which sign_i = (code_o <= target), the final word equals target, including targets 0 and 2^CODE_W-1.
- R5: done_o is high for exactly one cycle. It appears CODE_W*STEP_DIV cycles after the cycle in which busy_o first reads high, and busy_o reads low in the same cycle.
- R6: From the done pulse until the next search begins, code_o holds its final value.
- R7: A start_i pulse sampled while busy_o is 1 is ignored. This holds even on the last decision edge: neither the result nor the done timing changes.
- R8: If no start_i arrives, a new search begins on its own. busy_o rises and the MSB trial word reappears REPEAT_GAP*STEP_DIV+1 cycles after the cycle in which done_o was high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request to begin a search; honoured only while idle |
| sign_i | input | 1 | Saturated amplifier sign: 1 = under-compensated |
| code_o | output | CODE_W | Trim word driving the compensation DAC |
| busy_o | output | 1 | Search in progress |
| done_o | output | 1 | One-cycle pulse when the final word is valid |

## Verification
The bench drives sign_i from a behavioural loop model in two ways. In the first, sign_i comes from a monotonic comparison against a target word. In the second, sign_i is forced from a per-bit pattern, so that a kept/cleared polarity swap or an off-by-one bit order shows up as a wrong word at the intermediate decision points. The extreme targets 0 and full scale expose a design that never clears or never keeps the MSB. A start pulse placed on the very last decision edge catches a design that restarts instead of ignoring it, which shows up as late done timing. A long idle watch after done catches a code word that drifts, or an automatic rerun that fires one cycle early or late.

// File: rtl/trim_pkg.sv
package trim_pkg;
  typedef enum logic {
    PH_IDLE = 1'b0,
    PH_SEEK = 1'b1
  } phase_e;

  function automatic int safe_clog2(input int v);
    return (v > 1) ? $clog2(v) : 1;
  endfunction
endpackage

// File: rtl/trim_step_timer.sv
module trim_step_timer #(
  parameter int STEP_DIV = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic launch,
  input  logic run,
  output logic tick
);
  localparam int CW = trim_pkg::safe_clog2(STEP_DIV);

  generate
    if (STEP_DIV == 1) begin : g_every
      logic unused_launch;
      assign unused_launch = launch ^ clk ^ rst;
      assign tick = run;
    end else begin : g_count
      logic [CW-1:0] cnt;
      logic          at_end;
      assign at_end = (cnt == CW'(STEP_DIV - 1));
      always_ff @(posedge clk) begin
        if (rst) begin
          cnt <= '0;
        end else if (launch) begin
          cnt <= '0;
        end else if (run) begin
          cnt <= at_end ? '0 : cnt + 1'b1;
        end
      end
      assign tick = run && at_end;
    end
  endgenerate
endmodule

// File: rtl/trim_sar_core.sv
module trim_sar_core
  import trim_pkg::*;
#(
  parameter int CODE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              launch,
  input  logic              tick,
  input  logic              sign_i,
  output logic [CODE_W-1:0] code_o,
  output logic              busy_o,
  output logic              done_o
);
  localparam int MSB = CODE_W - 1;
  localparam logic [CODE_W-1:0] FIRST_TRIAL = CODE_W'(1) << MSB;

  phase_e            phase;
  logic [CODE_W-1:0] trial;
  logic [CODE_W-1:0] trial_nx;
  logic              decide;

  assign trial_nx = trial >> 1;
  assign decide   = (phase == PH_SEEK) && tick;
  assign busy_o   = (phase == PH_SEEK);

  // sequencing: one-hot pointer walks from MSB to LSB
  always_ff @(posedge clk) begin
    if (rst) begin
      phase  <= PH_IDLE;
      trial  <= '0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (launch) begin
        phase <= PH_SEEK;
        trial <= FIRST_TRIAL;
      end else if (decide) begin
        trial <= trial_nx;
        if (trial[0]) begin
          phase  <= PH_IDLE;
          done_o <= 1'b1;
        end
      end
    end
  end

  // per-bit slices: decide own bit when pointed at, become trial when next
  generate
    for (genvar i = 0; i < CODE_W; i++) begin : g_bit
      always_ff @(posedge clk) begin
        if (rst) begin
          code_o[i] <= 1'b0;
        end else if (launch) begin
          code_o[i] <= FIRST_TRIAL[i];
        end else if (decide) begin
          if (trial[i]) begin
            code_o[i] <= sign_i;
          end else if (trial_nx[i]) begin
            code_o[i] <= 1'b1;
          end
        end
      end
    end
  endgenerate
endmodule

// File: rtl/trim_repeat_sched.sv
module trim_repeat_sched #(
  parameter int STEP_DIV   = 4,
  parameter int REPEAT_GAP = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic done,
  input  logic busy,
  input  logic ext_start,
  output logic auto_go
);
  localparam int GAP_CYC = REPEAT_GAP * STEP_DIV;

  generate
    if (REPEAT_GAP == 0) begin : g_off
      logic unused_sched;
      assign unused_sched = done ^ busy ^ ext_start ^ clk ^ rst;
      assign auto_go = 1'b0;
    end else begin : g_on
      localparam int GW = trim_pkg::safe_clog2(GAP_CYC + 1);
      logic          armed;
      logic [GW-1:0] cnt;
      logic          expire;
      assign expire = armed && (cnt == GW'(GAP_CYC - 1));
      always_ff @(posedge clk) begin
        if (rst) begin
          armed <= 1'b0;
          cnt   <= '0;
        end else if (done) begin
          armed <= 1'b1;
          cnt   <= '0;
        end else if (busy || ext_start || expire) begin
          armed <= 1'b0;
          cnt   <= '0;
        end else if (armed) begin
          cnt <= cnt + 1'b1;
        end
      end
      assign auto_go = expire && !busy;
    end
  endgenerate
endmodule

// File: rtl/sar_offset_trim.sv
module sar_offset_trim #(
  parameter int CODE_W     = 8,
  parameter int STEP_DIV   = 4,
  parameter int REPEAT_GAP = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              sign_i,
  output logic [CODE_W-1:0] code_o,
  output logic              busy_o,
  output logic              done_o
);
  logic auto_go;
  logic launch;
  logic step_tick;

  assign launch = (start_i || auto_go) && !busy_o;

  trim_step_timer #(.STEP_DIV(STEP_DIV)) u_timer (
    .clk    (clk),
    .rst    (rst),
    .launch (launch),
    .run    (busy_o),
    .tick   (step_tick)
  );

  trim_sar_core #(.CODE_W(CODE_W)) u_core (
    .clk    (clk),
    .rst    (rst),
    .launch (launch),
    .tick   (step_tick),
    .sign_i (sign_i),
    .code_o (code_o),
    .busy_o (busy_o),
    .done_o (done_o)
  );

  trim_repeat_sched #(.STEP_DIV(STEP_DIV), .REPEAT_GAP(REPEAT_GAP)) u_sched (
    .clk       (clk),
    .rst       (rst),
    .done      (done_o),
    .busy      (busy_o),
    .ext_start (start_i),
    .auto_go   (auto_go)
  );
endmodule

// File: rtl/sar_offset_trim_checker.sv
module sar_offset_trim_checker #(
  parameter int CODE_W   = 8,
  parameter int STEP_DIV = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              start_i,
  input logic [CODE_W-1:0] code_o,
  input logic              busy_o,
  input logic              done_o
);
  localparam int LAT = CODE_W * STEP_DIV;
  localparam int BW  = $clog2(LAT + 2);
  localparam logic [CODE_W-1:0] MSB_ONLY = CODE_W'(1) << (CODE_W - 1);

  logic [BW-1:0] busy_cnt;
  always_ff @(posedge clk) begin
    if (rst || !busy_o) busy_cnt <= '0;
    else                busy_cnt <= busy_cnt + 1'b1;
  end

  AST_START_LOADS_MSB: assert property (@(posedge clk) disable iff (rst)
    (start_i && !busy_o) |=> (busy_o && code_o == MSB_ONLY)); // R2

  AST_ONE_BIT_STEP: assert property (@(posedge clk) disable iff (rst)
    (busy_o && $past(busy_o)) |-> ($countones(code_o ^ $past(code_o)) <= 2)); // R3

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o); // R5

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !busy_o); // R5

  AST_SEARCH_LENGTH: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_o) |-> (busy_cnt == BW'(LAT) && done_o)); // R5

  AST_HOLD_WHILE_IDLE: assert property (@(posedge clk) disable iff (rst)
    !busy_o |=> (busy_o || $stable(code_o))); // R6
endmodule

bind sar_offset_trim sar_offset_trim_checker #(
  .CODE_W   (CODE_W),
  .STEP_DIV (STEP_DIV)
) u_checker (
  .clk     (clk),
  .rst     (rst),
  .start_i (start_i),
  .code_o  (code_o),
  .busy_o  (busy_o),
  .done_o  (done_o)
);

// File: tb/sar_offset_trim_bench.sv
module sar_offset_trim_bench;
  localparam int CODE_W     = 8;
  localparam int STEP_DIV   = 4;
  localparam int REPEAT_GAP = 8;
  localparam int LAT        = CODE_W * STEP_DIV;
  localparam int GAP        = REPEAT_GAP * STEP_DIV;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic       sign;
  logic [7:0] code;
  logic       busy, done;
  logic       mode = 1'b0;
  logic [7:0] target = 8'd0;
  logic [7:0] pat = 8'd0;
  int         n_chk = 0, n_bad = 0, cyc = 0;

  always #4 clk = ~clk;

  sar_offset_trim #(.CODE_W(CODE_W), .STEP_DIV(STEP_DIV), .REPEAT_GAP(REPEAT_GAP)) u_sar_offset_trim (
    .clk(clk), .rst(rst), .start_i(start), .sign_i(sign),
    .code_o(code), .busy_o(busy), .done_o(done)
  );

  function automatic int low_idx(input logic [7:0] v);
    for (int i = 0; i < 8; i++) if (v[i]) return i;
    return 0;
  endfunction

  // loop model: monotonic comparison or forced per-bit pattern
  assign sign = mode ? pat[low_idx(code)] : (code <= target);

  function automatic logic [7:0] sar_ref(input logic [7:0] t);
    logic [7:0] w = 8'd0;
    for (int b = 7; b >= 0; b--) begin
      w[b] = 1'b1;
      if (!(w <= t)) w[b] = 1'b0;
    end
    return w;
  endfunction

  function automatic logic [7:0] partial(input logic [7:0] f, input int j);
    return (f & ~(8'hFF >> j)) | (8'h80 >> j);
  endfunction

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_search(input logic [7:0] expv, input int ign_at);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1 && code == 8'h80, "R2 msb trial load", code, 8'h80);
    for (int k = 1; k <= LAT; k++) begin
      if (k == ign_at) start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      if (k % STEP_DIV == 0 && k < LAT)
        chk(code == partial(expv, k / STEP_DIV), "R3 decision step", code, partial(expv, k / STEP_DIV));
      if (k == LAT - 1)
        chk(done == 1'b0 && busy == 1'b1, "R5 no early done", {busy, done}, 2'b10);
    end
    chk(done == 1'b1 && busy == 1'b0, "R5 done timing", {busy, done}, 2'b01);
    chk(code == expv, (ign_at > 0) ? "R7 result despite start" : "R4 final word", code, expv);
    @(negedge clk);
    chk(done == 1'b0, "R5 single pulse", done, 0);
  endtask

  task automatic mono(input logic [7:0] t, input int ign_at);
    mode = 1'b0; target = t;
    run_search(sar_ref(t), ign_at);
  endtask

  task automatic forced(input logic [7:0] p);
    mode = 1'b1; pat = p;
    run_search(p, 0);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=<100000", cyc);
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'd7731));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk(code == 8'd0 && busy == 1'b0 && done == 1'b0, "R1 reset state", {code, busy, done}, 0);
    repeat (GAP + 20) @(negedge clk);
    chk(busy == 1'b0 && code == 8'd0, "R1 no search without start", {code, busy}, 0);

    mono(8'd0, 0);
    mono(8'd255, 0);
    mono(8'd128, 0);
    mono(8'd127, 0);
    mono(8'd1, 0);
    forced(8'hA5);
    forced(8'h5A);
    mono(8'd77, 5);     // R7 mid-search start
    mono(8'd200, LAT);  // R7 start on last decision edge

    // R6 hold then R8 automatic rerun (already one cycle past done)
    for (int k = 2; k <= GAP; k++) begin
      @(negedge clk);
      chk(busy == 1'b0 && code == 8'd200, "R6 hold after done", code, 8'd200);
    end
    @(negedge clk);
    chk(busy == 1'b1 && code == 8'h80, "R8 automatic rerun", {busy, code}, {1'b1, 8'h80});
    repeat (LAT) @(negedge clk);
    chk(done == 1'b1 && code == 8'd200, "R8 rerun result", code, 8'd200);
    @(negedge clk);

    for (int n = 0; n < 20; n++) begin
      if ($urandom % 2 == 0) mono(8'($urandom), 0);
      else                   forced(8'($urandom));
    end
    finish_run();
  end
endmodule